// File: doc/BRIEF.md
# Multi-Hash Flow Record Cache

This block keeps one record per active network flow in an on-chip table. The flow key is the 5-tuple (both IP addresses, both ports, the protocol number). Each record also holds the time the flow was first seen, the time it was last seen and a packet count. For every packet the block looks at three candidate buckets, each picked by its own hash of the key. If one of them already holds the flow, that record is updated. Otherwise the packet takes an empty candidate. If there is none, the candidate that has been idle longest is pushed out on an output stream, and the new record goes into its place.

A record created by pushing another one out does not start with the current time as its last-seen time. It starts with the midpoint between the current time and the last-seen time of the record it displaced. A newcomer that never sees a second packet therefore stays the oldest entry in its bucket and is the first to go. When a record with a single packet leaves the table, its last-seen time is replaced by its first-seen time.

Control is a three-state machine. IDLE accepts a packet and moves to LOOKUP. LOOKUP reads and writes the three candidates in one cycle. It then returns to IDLE after a hit or a fill, or moves to EMIT when a record was displaced. EMIT holds the displaced record until the stream consumer takes it, then goes back to IDLE. Packets are accepted only in IDLE, so a stalled output stream stalls the packet input.

Top module: `flow_record_cache`

## Requirements
- R1: After reset every bucket is empty, `ev_valid` is 0 and `in_ready` is 1.
- R2: The key is the 104-bit value {src_ip[103:72], dst_ip[71:40], src_port[39:24], dst_port[23:8], proto[7:0]}. Let F be the XOR of its twenty-six 4-bit slices. Candidate j (j = 0, 1, 2) is bucket F XOR ((5*j) mod 16) of a 16-bucket table.
- R3: When a valid candidate holds the same key, that record's count is incremented, saturating at all ones, and its last-seen time is set to the packet's timestamp. Its first-seen time is kept and no record is output.
- R4: When no candidate matches and at least one is empty, the lowest-numbered empty candidate receives a record with first-seen = last-seen = timestamp and count = 1. No record is output, and a filled bucket never becomes empty again.
- R5: When no candidate matches and all three are occupied, the candidate with the smallest last-seen time is output, with ties going to the lowest candidate number.
- R6: The record that replaces a displaced one gets first-seen = timestamp, count = 1 and last-seen = floor((displaced last-seen + timestamp) / 2).
- R7: An output record whose count is 1 carries its first-seen time in the last-seen field, so an output record's last-seen time is never below its first-seen time.
- R8: While `ev_valid` is 1 and `ev_ready` is 0, `in_ready` is 0 and every output field holds its value.
- R9: A packet is taken on a rising edge where `in_valid` and `in_ready` are both 1, with the `now_ts` value present at that edge. A displaced record is shown with `ev_valid` high after the next rising edge. After a hit or fill, `in_ready` is high again after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Packet key present |
| in_ready | output | 1 | Block can take a packet |
| in_src_ip | input | 32 | Source IP address |
| in_dst_ip | input | 32 | Destination IP address |
| in_src_port | input | 16 | Source port |
| in_dst_port | input | 16 | Destination port |
| in_proto | input | 8 | Protocol number |
| now_ts | input | TS_W | Free-running timestamp |
| ev_valid | output | 1 | Displaced record present |
| ev_ready | input | 1 | Consumer takes the displaced record |
| ev_src_ip | output | 32 | Displaced record source IP |
| ev_dst_ip | output | 32 | Displaced record destination IP |
| ev_src_port | output | 16 | Displaced record source port |
| ev_dst_port | output | 16 | Displaced record destination port |
| ev_proto | output | 8 | Displaced record protocol |
| ev_start | output | TS_W | Displaced record first-seen time |
| ev_end | output | TS_W | Displaced record last-seen time (corrected per R7) |
| ev_count | output | CNT_W | Displaced record packet count |

## Verification
The bench starts with a directed sequence on keys that share one candidate set.

- A hit between fills changes which record is oldest. A design that failed to refresh the last-seen time on a hit would displace the wrong flow.
- A newcomer is followed by an older-looking resident. A design that gave new records the raw current time would displace the resident instead of the newcomer.
- A single-packet record is displaced. A design that skipped the correction would output a last-seen time that differs from its first-seen time.

After that, random keys with overlapping candidate sets, idle gaps and output stalls are checked against a bench model of the table. This phase brings out:

- ties on last-seen time;
- wrong choice among several empty buckets;
- wrong hash slicing, which shows as a displaced key or a timing the model did not predict;
- any packet accepted while the output is stalled.

// File: rtl/flow_cache_pkg.sv
package flow_cache_pkg;

    localparam int KEY_W = 104;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOOKUP,
        S_EMIT
    } fc_state_e;

    typedef enum logic [1:0] {
        M_HIT,
        M_FILL,
        M_EVICT
    } fc_mode_e;

endpackage

// File: rtl/fc_hash.sv
module fc_hash
    import flow_cache_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int NUM_HASH  = 3,
    parameter int HASH_STEP = 5
) (
    input  logic [KEY_W-1:0] key_i,
    output logic [IDX_W-1:0] idx_o [NUM_HASH]
);
    localparam int CHUNKS = (KEY_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = CHUNKS * IDX_W;

    logic [PAD_W-1:0] padded;
    logic [IDX_W-1:0] folded;

    assign padded = PAD_W'(key_i);

    // XOR-fold of the key into one bucket-sized word
    always_comb begin
        folded = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            folded = folded ^ padded[c*IDX_W +: IDX_W];
        end
    end

    // each candidate applies its own distinct salt, so the three buckets never coincide
    for (genvar j = 0; j < NUM_HASH; j++) begin : g_salt
        assign idx_o[j] = folded ^ IDX_W'((j * HASH_STEP) % (1 << IDX_W));
    end

endmodule

// File: rtl/fc_table.sv
module fc_table
    import flow_cache_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int TS_W     = 32,
    parameter int CNT_W    = 16,
    parameter int NUM_HASH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] wsel_i,
    input  logic [KEY_W-1:0] wkey_i,
    input  logic [TS_W-1:0]  wstart_i,
    input  logic [TS_W-1:0]  wend_i,
    input  logic [CNT_W-1:0] wcnt_i,
    input  logic [IDX_W-1:0] rd_idx_i   [NUM_HASH],
    output logic             rd_vld_o   [NUM_HASH],
    output logic [KEY_W-1:0] rd_key_o   [NUM_HASH],
    output logic [TS_W-1:0]  rd_start_o [NUM_HASH],
    output logic [TS_W-1:0]  rd_end_o   [NUM_HASH],
    output logic [CNT_W-1:0] rd_cnt_o   [NUM_HASH]
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    logic [KEY_W-1:0] key_q   [DEPTH];
    logic [TS_W-1:0]  start_q [DEPTH];
    logic [TS_W-1:0]  end_q   [DEPTH];
    logic [CNT_W-1:0] cnt_q   [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (we_i) begin
            vld_q[wsel_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we_i) begin
            key_q[wsel_i]   <= wkey_i;
            start_q[wsel_i] <= wstart_i;
            end_q[wsel_i]   <= wend_i;
            cnt_q[wsel_i]   <= wcnt_i;
        end
    end

    for (genvar j = 0; j < NUM_HASH; j++) begin : g_rd
        assign rd_vld_o[j]   = vld_q[rd_idx_i[j]];
        assign rd_key_o[j]   = key_q[rd_idx_i[j]];
        assign rd_start_o[j] = start_q[rd_idx_i[j]];
        assign rd_end_o[j]   = end_q[rd_idx_i[j]];
        assign rd_cnt_o[j]   = cnt_q[rd_idx_i[j]];
    end

    // occupied buckets stay occupied (R4)
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((vld_q & $past(vld_q)) == $past(vld_q)));

endmodule

// File: rtl/fc_select.sv
module fc_select
    import flow_cache_pkg::*;
#(
    parameter int TS_W     = 32,
    parameter int NUM_HASH = 3,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             check_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             vld_i      [NUM_HASH],
    input  logic [KEY_W-1:0] cand_key_i [NUM_HASH],
    input  logic [TS_W-1:0]  end_i      [NUM_HASH],
    output fc_mode_e         mode_o,
    output logic [SEL_W-1:0] sel_o
);
    logic             hit_f, emp_f;
    logic [SEL_W-1:0] hit_j, emp_j, old_j;

    always_comb begin
        hit_f = 1'b0;
        emp_f = 1'b0;
        hit_j = '0;
        emp_j = '0;
        old_j = '0;
        for (int j = 0; j < NUM_HASH; j++) begin
            if (!hit_f && vld_i[j] && (cand_key_i[j] == key_i)) begin
                hit_f = 1'b1;
                hit_j = SEL_W'(j);
            end
            if (!emp_f && !vld_i[j]) begin
                emp_f = 1'b1;
                emp_j = SEL_W'(j);
            end
            // strict compare keeps the lowest index on a tie
            if (end_i[j] < end_i[old_j]) begin
                old_j = SEL_W'(j);
            end
        end
    end

    always_comb begin
        if (hit_f) begin
            mode_o = M_HIT;
            sel_o  = hit_j;
        end else if (emp_f) begin
            mode_o = M_FILL;
            sel_o  = emp_j;
        end else begin
            mode_o = M_EVICT;
            sel_o  = old_j;
        end
    end

    // independent check: no candidate beats the chosen victim on age or on index
    logic [NUM_HASH-1:0] beats;
    for (genvar j = 0; j < NUM_HASH; j++) begin : g_beat
        assign beats[j] = (end_i[j] < end_i[sel_o]) ||
                          ((SEL_W'(j) < sel_o) && (end_i[j] == end_i[sel_o]));
    end

    assert_oldest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (check_i && (mode_o == M_EVICT)) |-> (beats == '0));

endmodule

// File: rtl/flow_record_cache.sv
module flow_record_cache
    import flow_cache_pkg::*;
#(
    parameter int TS_W      = 32,
    parameter int CNT_W     = 16,
    parameter int IDX_W     = 4,
    parameter int NUM_HASH  = 3,
    parameter int HASH_STEP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_src_ip,
    input  logic [31:0]      in_dst_ip,
    input  logic [15:0]      in_src_port,
    input  logic [15:0]      in_dst_port,
    input  logic [7:0]       in_proto,
    input  logic [TS_W-1:0]  now_ts,
    output logic             ev_valid,
    input  logic             ev_ready,
    output logic [31:0]      ev_src_ip,
    output logic [31:0]      ev_dst_ip,
    output logic [15:0]      ev_src_port,
    output logic [15:0]      ev_dst_port,
    output logic [7:0]       ev_proto,
    output logic [TS_W-1:0]  ev_start,
    output logic [TS_W-1:0]  ev_end,
    output logic [CNT_W-1:0] ev_count
);
    localparam int SEL_W = (NUM_HASH > 1) ? $clog2(NUM_HASH) : 1;

    fc_state_e        state_q, state_d;
    fc_mode_e         mode;
    logic [SEL_W-1:0] sel;

    logic [KEY_W-1:0] in_key, lk_key;
    logic [TS_W-1:0]  lk_ts;

    logic [IDX_W-1:0] cand     [NUM_HASH];
    logic             rd_vld   [NUM_HASH];
    logic [KEY_W-1:0] rd_key   [NUM_HASH];
    logic [TS_W-1:0]  rd_start [NUM_HASH];
    logic [TS_W-1:0]  rd_end   [NUM_HASH];
    logic [CNT_W-1:0] rd_cnt   [NUM_HASH];

    logic             we;
    logic [IDX_W-1:0] wsel;
    logic [TS_W-1:0]  wstart, wend;
    logic [CNT_W-1:0] wcnt;
    logic [TS_W:0]    age_sum;

    logic [KEY_W-1:0] ev_key_q;
    logic [TS_W-1:0]  ev_start_q, ev_end_q;
    logic [CNT_W-1:0] ev_cnt_q;

    assign in_key = {in_src_ip, in_dst_ip, in_src_port, in_dst_port, in_proto};

    fc_hash #(
        .IDX_W    (IDX_W),
        .NUM_HASH (NUM_HASH),
        .HASH_STEP(HASH_STEP)
    ) u_hash (
        .key_i(lk_key),
        .idx_o(cand)
    );

    fc_table #(
        .IDX_W   (IDX_W),
        .TS_W    (TS_W),
        .CNT_W   (CNT_W),
        .NUM_HASH(NUM_HASH)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (we),
        .wsel_i    (wsel),
        .wkey_i    (lk_key),
        .wstart_i  (wstart),
        .wend_i    (wend),
        .wcnt_i    (wcnt),
        .rd_idx_i  (cand),
        .rd_vld_o  (rd_vld),
        .rd_key_o  (rd_key),
        .rd_start_o(rd_start),
        .rd_end_o  (rd_end),
        .rd_cnt_o  (rd_cnt)
    );

    fc_select #(
        .TS_W    (TS_W),
        .NUM_HASH(NUM_HASH),
        .SEL_W   (SEL_W)
    ) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .check_i   (state_q == S_LOOKUP),
        .key_i     (lk_key),
        .vld_i     (rd_vld),
        .cand_key_i(rd_key),
        .end_i     (rd_end),
        .mode_o    (mode),
        .sel_o     (sel)
    );

    // midpoint of displaced last-seen time and the packet time
    assign age_sum = {1'b0, rd_end[sel]} + {1'b0, lk_ts};

    // record write data for the bucket selected in LOOKUP
    always_comb begin
        we     = (state_q == S_LOOKUP);
        wsel   = cand[sel];
        wstart = lk_ts;
        wend   = lk_ts;
        wcnt   = CNT_W'(1);
        unique case (mode)
            M_HIT: begin
                wstart = rd_start[sel];
                wcnt   = (&rd_cnt[sel]) ? rd_cnt[sel] : rd_cnt[sel] + CNT_W'(1);
            end
            M_FILL: begin
                wend = lk_ts;
            end
            M_EVICT: begin
                wend = age_sum[TS_W:1];
            end
            default: begin
                wend = lk_ts;
            end
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (in_valid) state_d = S_LOOKUP;
            S_LOOKUP: state_d = (mode == M_EVICT) ? S_EMIT : S_IDLE;
            S_EMIT:   if (ev_ready) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // packet capture and displaced-record registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_key     <= '0;
            lk_ts      <= '0;
            ev_key_q   <= '0;
            ev_start_q <= '0;
            ev_end_q   <= '0;
            ev_cnt_q   <= '0;
        end else begin
            if ((state_q == S_IDLE) && in_valid) begin
                lk_key <= in_key;
                lk_ts  <= now_ts;
            end
            if ((state_q == S_LOOKUP) && (mode == M_EVICT)) begin
                ev_key_q   <= rd_key[sel];
                ev_start_q <= rd_start[sel];
                ev_cnt_q   <= rd_cnt[sel];
                ev_end_q   <= (rd_cnt[sel] == CNT_W'(1)) ? rd_start[sel] : rd_end[sel];
            end
        end
    end

    // output decode
    always_comb begin
        in_ready = 1'b0;
        ev_valid = 1'b0;
        unique case (state_q)
            S_IDLE:   in_ready = 1'b1;
            S_LOOKUP: in_ready = 1'b0;
            S_EMIT:   ev_valid = 1'b1;
            default:  in_ready = 1'b0;
        endcase
    end

    assign ev_src_ip   = ev_key_q[103:72];
    assign ev_dst_ip   = ev_key_q[71:40];
    assign ev_src_port = ev_key_q[39:24];
    assign ev_dst_port = ev_key_q[23:8];
    assign ev_proto    = ev_key_q[7:0];
    assign ev_start    = ev_start_q;
    assign ev_end      = ev_end_q;
    assign ev_count    = ev_cnt_q;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_key_q) && $stable(ev_start)
                                     && $stable(ev_end) && $stable(ev_count)));

    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> !in_ready);

    assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (ev_end >= ev_start));

    assert_oneflight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !ev_valid));

endmodule

// File: tb/flow_record_cache_tb.sv
module flow_record_cache_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_src_ip = '0, in_dst_ip = '0;
    logic [15:0] in_src_port = '0, in_dst_port = '0;
    logic [7:0]  in_proto = '0;
    logic [31:0] now_ts = '0;
    logic        ev_valid;
    logic        ev_ready = 1'b0;
    logic [31:0] ev_src_ip, ev_dst_ip;
    logic [15:0] ev_src_port, ev_dst_port;
    logic [7:0]  ev_proto;
    logic [31:0] ev_start, ev_end;
    logic [15:0] ev_count;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // bench model of the table
    logic         m_vld   [16];
    logic [103:0] m_key   [16];
    logic [31:0]  m_start [16];
    logic [31:0]  m_end   [16];
    logic [15:0]  m_cnt   [16];

    logic [103:0] pool [24];

    always #2.5 clk = ~clk;

    always @(posedge clk) now_ts <= now_ts + 32'd1;

    flow_record_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_src_ip(in_src_ip), .in_dst_ip(in_dst_ip),
        .in_src_port(in_src_port), .in_dst_port(in_dst_port), .in_proto(in_proto),
        .now_ts(now_ts),
        .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_src_ip(ev_src_ip), .ev_dst_ip(ev_dst_ip),
        .ev_src_port(ev_src_port), .ev_dst_port(ev_dst_port), .ev_proto(ev_proto),
        .ev_start(ev_start), .ev_end(ev_end), .ev_count(ev_count)
    );

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL R9 watchdog: cycles=%0d expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] fold(input logic [103:0] k);
        logic [3:0] f = 4'h0;
        for (int i = 0; i < 26; i++) f = f ^ k[i*4 +: 4];
        return f;
    endfunction

    function automatic logic [103:0] make_key(input logic [3:0] target);
        logic [103:0] k;
        k = {$urandom(), $urandom(), $urandom(), 8'($urandom())};
        k[3:0] = k[3:0] ^ fold(k) ^ target;
        return k;
    endfunction

    task automatic send(input logic [103:0] k, input int stall);
        logic [31:0]  t;
        int           b [3];
        int           hj, ej, vj;
        bit           exp_ev;
        logic [103:0] x_key;
        logic [31:0]  x_start, x_end;
        logic [15:0]  x_cnt;
        exp_ev = 1'b0;
        @(negedge clk);
        in_valid = 1'b1;
        {in_src_ip, in_dst_ip, in_src_port, in_dst_port, in_proto} = k;
        while (!in_ready) @(negedge clk);
        t = now_ts;
        @(negedge clk);
        in_valid = 1'b0;
        // model per R2..R6
        for (int j = 0; j < 3; j++) b[j] = int'(fold(k) ^ 4'((j * 5) % 16));
        hj = -1;
        ej = -1;
        for (int j = 0; j < 3; j++) if (hj < 0 && m_vld[b[j]] && m_key[b[j]] == k) hj = j;
        for (int j = 0; j < 3; j++) if (ej < 0 && !m_vld[b[j]]) ej = j;
        if (hj >= 0) begin
            if (m_cnt[b[hj]] != 16'hffff) m_cnt[b[hj]] = m_cnt[b[hj]] + 16'd1;
            m_end[b[hj]] = t;
        end else if (ej >= 0) begin
            m_vld[b[ej]] = 1'b1;
            m_key[b[ej]] = k;
            m_start[b[ej]] = t;
            m_end[b[ej]] = t;
            m_cnt[b[ej]] = 16'd1;
        end else begin
            vj = 0;
            for (int j = 1; j < 3; j++) if (m_end[b[j]] < m_end[b[vj]]) vj = j;
            exp_ev  = 1'b1;
            x_key   = m_key[b[vj]];
            x_start = m_start[b[vj]];
            x_cnt   = m_cnt[b[vj]];
            x_end   = (x_cnt == 16'd1) ? x_start : m_end[b[vj]];
            m_key[b[vj]]   = k;
            m_start[b[vj]] = t;
            m_end[b[vj]]   = 32'((longint'(m_end[b[vj]]) + longint'(t)) / 2);
            m_cnt[b[vj]]   = 16'd1;
        end
        @(negedge clk);
        if (exp_ev) begin
            check("R9", "ev_valid one edge after lookup", 64'(ev_valid), 64'd1);
            check("R2", "displaced key", 64'({ev_src_ip, ev_dst_ip}), 64'(x_key[103:40]));
            check("R2", "displaced ports/proto", 64'({ev_src_port, ev_dst_port, ev_proto}), 64'(x_key[39:0]));
            check("R5", "displaced count", 64'(ev_count), 64'(x_cnt));
            check("R6", "displaced first-seen", 64'(ev_start), 64'(x_start));
            check("R7", "displaced last-seen", 64'(ev_end), 64'(x_end));
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                check("R8", "ev_valid held in stall", 64'(ev_valid), 64'd1);
                check("R8", "in_ready low in stall", 64'(in_ready), 64'd0);
                check("R8", "ev_end held in stall", 64'(ev_end), 64'(x_end));
            end
            ev_ready = 1'b1;
            @(negedge clk);
            ev_ready = 1'b0;
            check("R8", "ev_valid drops after handshake", 64'(ev_valid), 64'd0);
            check("R9", "in_ready back after handshake", 64'(in_ready), 64'd1);
        end else begin
            check("R3", "no output on hit or fill", 64'(ev_valid), 64'd0);
            check("R4", "in_ready back after hit or fill", 64'(in_ready), 64'd1);
        end
    endtask

    initial begin
        logic [103:0] ka, kb, kc, kd, ke;
        void'($urandom(20240611));
        for (int i = 0; i < 16; i++) begin
            m_vld[i] = 1'b0;
            m_key[i] = '0;
            m_start[i] = '0;
            m_end[i] = '0;
            m_cnt[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "in_ready after reset", 64'(in_ready), 64'd1);
        check("R1", "ev_valid after reset", 64'(ev_valid), 64'd0);

        // directed: five keys sharing candidate set {3,6,9}
        ka = make_key(4'd3);
        kb = make_key(4'd3);
        kc = make_key(4'd3);
        kd = make_key(4'd3);
        ke = make_key(4'd3);
        send(ka, 0);                  // R4 fill bucket 3
        send(ka, 0);                  // R3 hit, count 2
        repeat (1000) @(negedge clk);
        send(kb, 0);                  // R4 fill
        send(kc, 0);                  // R4 fill
        send(kd, 2);                  // R5 displaces A (count 2, refreshed end), R8 stall
        send(ke, 1);                  // R6 displaces D (midpoint below B), R7 single-packet fix
        send(kb, 0);                  // R3 hit on survivor
        send(ka, 3);                  // A returns, displaces oldest

        // random phase with overlapping candidate sets
        for (int i = 0; i < 24; i++) pool[i] = make_key(4'($urandom_range(0, 7)));
        for (int n = 0; n < 700; n++) begin
            repeat ($urandom_range(0, 3)) @(negedge clk);
            send(pool[$urandom_range(0, 23)], int'($urandom_range(0, 3)));
        end

        done = 1'b1;
        finish_run();
    end

endmodule